// File: doc/BRIEF.md
# Memoryless XOR Output Scrambler

This block whitens 12-bit converter samples just before they are put on a parallel output bus, one sample per clock. Repeating data patterns put strong tones on the output wires. To break them up, every upper data bit is XORed with a one-bit key. The key is the XOR of the two lowest active bits of the same sample. No state is carried from one sample to the next, so a receiver can undo the operation on each word by itself. The key bits themselves are sent in a form the receiver can invert.

The output bus can run at reduced resolution: 12, 11, 10 or 8 active bits. The width mode moves the key bits upward and forces the unused low bits to zero. Bit 0 can carry a timestamp in the narrow modes. The strobe that travels with each sample is scrambled with the same key. When scrambling is off, data and strobe pass through unchanged, and the width mode still zeroes the unused bits. All outputs are registered once, and a valid flag travels with them.

Top module: `xor_lane_scrambler`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sample` and `out_strobe` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. A sample presented with `in_valid` high appears on the outputs after exactly one rising edge.
- R3: In a cycle with `in_valid` low, `out_sample` and `out_strobe` keep their previous values. Changes on `scr_en`, `width_sel` or `ts_lsb` in that cycle have no effect on them.
- R4: With `width_sel`=0 (12-bit) and scrambling on, the key is d[1]^d[0]. Bits 11..2 are d[k]^key, y[1]=d[1] and y[0]=d[0]^d[1].
- R5: With `width_sel`=1 (11-bit) and scrambling on, the key is d[2]^d[1]. Bits 11..3 are d[k]^key, y[2]=d[2] and y[1]=d[2]^d[1].
- R6: With `width_sel`=2 (10-bit) and scrambling on, the key is d[3]^d[2]. Bits 11..4 are d[k]^key, y[3]=d[3] and y[2]=d[2]^d[3]. y[1] is 0 whether scrambling is on or off.
- R7: With `width_sel`=3 (8-bit) and scrambling on, the key is d[5]^d[4]. Bits 11..6 are d[k]^key, y[5]=d[5] and y[4]=d[4]^d[5]. y[3:1] are 0 whether scrambling is on or off.
- R8: In width modes 1, 2 and 3, y[0] is 0 when `ts_lsb` is 0. When `ts_lsb` is 1, y[0] is d[0]^key with scrambling on and d[0] with scrambling off.
- R9: With scrambling on, `out_strobe` is the input strobe XORed with the current mode's key.
- R10: With `scr_en` low, the active data bits and the strobe equal their inputs. The unused bits are still zeroed as in R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A new sample is present this cycle |
| in_sample | input | 12 | Unscrambled sample |
| in_strobe | input | 1 | Strobe bit belonging to the sample |
| scr_en | input | 1 | 1 = scramble, 0 = bypass |
| width_sel | input | 2 | Output width: 0=12, 1=11, 2=10, 3=8 bits |
| ts_lsb | input | 1 | Bit 0 carries a timestamp in the narrow modes |
| out_valid | output | 1 | Registered copy of in_valid |
| out_sample | output | 12 | Scrambled, width-masked sample |
| out_strobe | output | 1 | Scrambled strobe |

## Verification
Two things can meet in the same cycle: the width-mode masking and the key XOR. In the narrow modes the XOR must act on the shifted key bits, while the bits below them are forced to zero. Bit 0 is the harshest spot, because it is masked, passed or scrambled depending on `ts_lsb` and `scr_en`. Random samples are mixed with random mode, enable, `ts_lsb` and valid settings, and each output word is compared bit for bit against a bench model written per mode. Directed words with alternating and all-one patterns are added, together with idle cycles in which the mode changes.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
  localparam int unsigned SAMPLE_W = 12;
  localparam int unsigned IDX_W    = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    WM_FULL   = 2'd0,
    WM_MINUS1 = 2'd1,
    WM_MINUS2 = 2'd2,
    WM_MINUS4 = 2'd3
  } wmode_e;

  // lower of the two key bit positions for each width mode
  function automatic logic [IDX_W-1:0] key_base(input wmode_e m);
    case (m)
      WM_FULL:   key_base = IDX_W'(0);
      WM_MINUS1: key_base = IDX_W'(1);
      WM_MINUS2: key_base = IDX_W'(2);
      default:   key_base = IDX_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/xsc_rst_sync.sv
module xsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xsc_key_pick.sv
module xsc_key_pick
  import xsc_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic [W-1:0]     d,
  input  wmode_e           mode,
  output logic [IDX_W-1:0] base,
  output logic             key
);
  always_comb begin
    base = key_base(mode);
    key  = d[base] ^ d[base + IDX_W'(1)];
  end
endmodule

// File: rtl/xsc_mixer.sv
module xsc_mixer
  import xsc_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic [W-1:0]     d,
  input  logic             strobe,
  input  logic             en,
  input  logic             ts_lsb,
  input  logic [IDX_W-1:0] base,
  input  logic             key,
  output logic [W-1:0]     y,
  output logic             y_strobe
);
  logic eff_key;

  always_comb begin
    eff_key  = en & key;
    y_strobe = strobe ^ eff_key;
  end

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_bit
      if (k == 0) begin : g_lsb
        always_comb begin
          if (base == '0)
            y[0] = en ? (d[0] ^ d[1]) : d[0];
          else if (ts_lsb)
            y[0] = d[0] ^ eff_key;
          else
            y[0] = 1'b0;
        end
      end else begin : g_up
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        always_comb begin
          if (KI > base + IDX_W'(1))
            y[k] = d[k] ^ eff_key;
          else if (KI == base + IDX_W'(1))
            y[k] = d[k];
          else if (KI == base)
            y[k] = en ? (d[k] ^ d[k+1]) : d[k];
          else
            y[k] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xsc_out_reg.sv
module xsc_out_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] y_in,
  input  logic         s_in,
  output logic         v_out,
  output logic [W-1:0] y_out,
  output logic         s_out
);
  logic [W-1:0] y_d;
  logic         s_d;

  always_comb begin
    y_d = y_out;
    s_d = s_out;
    if (load) begin
      y_d = y_in;
      s_d = s_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      y_out <= '0;
      s_out <= 1'b0;
    end else begin
      v_out <= load;
      y_out <= y_d;
      s_out <= s_d;
    end
  end
endmodule

// File: rtl/xor_lane_scrambler.sv
module xor_lane_scrambler
  import xsc_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic         in_strobe,
  input  logic         scr_en,
  input  logic [1:0]   width_sel,
  input  logic         ts_lsb,
  output logic         out_valid,
  output logic [W-1:0] out_sample,
  output logic         out_strobe
);
  logic             rst_n_i;
  logic [IDX_W-1:0] base;
  logic             key;
  logic [W-1:0]     mixed;
  logic             mixed_strobe;
  wmode_e           mode;

  assign mode = wmode_e'(width_sel);

  xsc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  xsc_key_pick #(.W(W)) u_key (
    .d(in_sample), .mode(mode), .base(base), .key(key)
  );

  xsc_mixer #(.W(W)) u_mix (
    .d(in_sample), .strobe(in_strobe), .en(scr_en), .ts_lsb(ts_lsb),
    .base(base), .key(key), .y(mixed), .y_strobe(mixed_strobe)
  );

  xsc_out_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n_i), .load(in_valid),
    .y_in(mixed), .s_in(mixed_strobe),
    .v_out(out_valid), .y_out(out_sample), .s_out(out_strobe)
  );
endmodule

// File: rtl/xsc_checker.sv
module xsc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [11:0] in_sample,
  input logic        in_strobe,
  input logic        scr_en,
  input logic [1:0]  width_sel,
  input logic        ts_lsb,
  input logic        out_valid,
  input logic [11:0] out_sample,
  input logic        out_strobe
);
  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (out_valid == 1'b0 && out_sample == '0 && out_strobe == 1'b0);
    end
  end

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sample) && $stable(out_strobe)));

  // R4
  a_r4_key_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scr_en && width_sel == 2'd0) |=> out_sample[1] == $past(in_sample[1]));

  // R6
  a_r6_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'd2) |=> out_sample[1] == 1'b0);

  // R7
  a_r7_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'd3) |=> out_sample[3:1] == 3'b000);

  // R8
  a_r8_lsb_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel != 2'd0 && !ts_lsb) |=> out_sample[0] == 1'b0);

  // R9: in 12-bit mode y[0] carries the key itself
  a_r9_strobe_key: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scr_en && width_sel == 2'd0) |=> out_strobe == ($past(in_strobe) ^ out_sample[0]));

  // R10
  a_r10_bypass_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scr_en && width_sel == 2'd0) |=>
      (out_sample == $past(in_sample) && out_strobe == $past(in_strobe)));
endmodule

bind xor_lane_scrambler xsc_checker u_xsc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .in_strobe(in_strobe), .scr_en(scr_en), .width_sel(width_sel), .ts_lsb(ts_lsb),
  .out_valid(out_valid), .out_sample(out_sample), .out_strobe(out_strobe)
);

// File: tb/test_xor_lane_scrambler.sv
module test_xor_lane_scrambler;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_sample;
  logic        in_strobe;
  logic        scr_en;
  logic [1:0]  width_sel;
  logic        ts_lsb;
  logic        out_valid;
  logic [11:0] out_sample;
  logic        out_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  logic        e_valid;
  logic [11:0] e_sample;
  logic        e_strobe;
  logic        done = 1'b0;

  xor_lane_scrambler i_xor_lane_scrambler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_strobe(in_strobe), .scr_en(scr_en), .width_sel(width_sel), .ts_lsb(ts_lsb),
    .out_valid(out_valid), .out_sample(out_sample), .out_strobe(out_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(input logic [1:0] m, input logic en);
    if (!en) return "R10";
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // per-mode model of the output word
  function automatic logic [12:0] model(input logic [11:0] d, input logic s,
                                        input logic en, input logic [1:0] m, input logic ts);
    logic [11:0] y;
    logic k;
    int lo;
    y = '0;
    case (m)
      2'd0: lo = 0;
      2'd1: lo = 1;
      2'd2: lo = 2;
      default: lo = 4;
    endcase
    k = en ? (d[lo] ^ d[lo+1]) : 1'b0;
    for (int i = lo + 2; i < 12; i++) y[i] = d[i] ^ k;
    y[lo+1] = d[lo+1];
    y[lo]   = en ? (d[lo] ^ d[lo+1]) : d[lo];
    if (m != 2'd0) y[0] = ts ? (d[0] ^ k) : 1'b0;
    return {s ^ k, y};
  endfunction

  task automatic check(input string req);
    n_cmp++;
    if (out_valid !== e_valid || out_sample !== e_sample || out_strobe !== e_strobe) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%h s=%b, expected v=%b d=%h s=%b",
               req, out_valid, out_sample, out_strobe, e_valid, e_sample, e_strobe);
    end
  endtask

  // drive at negedge; outputs checked at the following negedge
  task automatic step(input logic v, input logic [11:0] d, input logic s,
                      input logic en, input logic [1:0] m, input logic ts);
    logic [12:0] r;
    in_valid = v; in_sample = d; in_strobe = s; scr_en = en; width_sel = m; ts_lsb = ts;
    e_valid = v;
    if (v) begin
      r = model(d, s, en, m, ts);
      e_sample = r[11:0];
      e_strobe = r[12];
    end
    @(negedge clk);
    if (v) check(req_of(m, en));
    else   check("R3/R2");
  endtask

  initial begin
    logic [11:0] pats [6];
    process::self().srandom(32'd1234);
    rst_n = 1'b0;
    in_valid = 1'b0; in_sample = '0; in_strobe = 1'b0;
    scr_en = 1'b0; width_sel = 2'd0; ts_lsb = 1'b0;
    e_valid = 1'b0; e_sample = '0; e_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hAAA;
    pats[3] = 12'h555; pats[4] = 12'h0F3; pats[5] = 12'h9C6;
    // directed: every mode, enable, ts and strobe on fixed words (R4..R10, R8, R9)
    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 8; c++)
          step(1'b1, pats[p], c[0], c[1], m[1:0], c[2]);

    // R3: idle cycles while mode/enable toggle leave outputs held
    step(1'b1, 12'h7B1, 1'b1, 1'b1, 2'd3, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 12'hFFF, 1'b0, i[0], i[1:0], ~i[0]);

    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 12'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom));

    // R1: reset in mid-run
    in_valid = 1'b0;
    rst_n = 1'b0;
    e_valid = 1'b0; e_sample = '0; e_strobe = 1'b0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule